// File: doc/BRIEF.md
# Per-Hart Software Interrupt Bank

This block holds one software-interrupt pending bit per hart and drives it straight onto that hart's interrupt line. Software raises an interrupt on another hart by writing a 32-bit word into a small bus-mapped bank. Hart `i` owns the word at byte offset `4*i`. Only bit 0 of each word carries meaning.

A build-time parameter picks one of two personalities. In machine personality each word is a normal read/write flag: writing 1 raises the line, writing 0 drops it, and reads return the flag. Reset clears every flag. In supervisor personality the bus can only raise lines. Writing 0 does nothing, every read returns zero, and reset leaves the lines alone. The owning hart drops its line by pulsing its acknowledge input.

The bus uses plain strobes with no handshake and no back-pressure. The block accepts a write or read in every cycle that `bus_wr` or `bus_rd` is high. Read data appears on `bus_rdata` in the cycle after `bus_rd`. In every other cycle `bus_rdata` is zero.

Top module: `swi_bank`

## Requirements
- R1: Hart `i` is addressed at byte offset `4*i`. A write with bit 0 set raises `sw_irq[i]` from the next clock edge.
- R2: In machine personality, a write with bit 0 clear lowers that hart's line. Bits 31:1 of the write data are ignored.
- R3: In machine personality, a read returns the hart's pending bit in bit 0 with bits 31:1 zero, on `bus_rdata` in the cycle after `bus_rd`. In all other cycles `bus_rdata` is zero.
- R4: In supervisor personality, `bus_rdata` is zero for every read.
- R5: In supervisor personality, a write with bit 0 clear leaves the addressed line unchanged.
- R6: In supervisor personality, a pulse on `hart_ack[i]` lowers `sw_irq[i]` at the next edge. A set write and an acknowledge to the same hart in the same cycle leave the line raised.
- R7: In machine personality, `hart_ack` has no effect on any line.
- R8: An access whose address bits 1:0 are not 00 changes no line and reads as zero.
- R9: An access to a word index at or above the hart count changes no line and reads as zero.
- R10: In machine personality, synchronous reset clears every line and `bus_rdata`.
- R11: In supervisor personality, reset leaves every line unchanged.
- R12: A read and a write to the same hart in the same cycle return the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | ADDR_W | Byte address within the bank |
| bus_wdata | input | 32 | Write data; only bit 0 is used |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd`, else zero |
| hart_ack | input | HARTS | Per-hart clear pulse (supervisor personality only) |
| sw_irq | output | HARTS | Per-hart software interrupt lines |

## Verification
The hardest situation to reach is a supervisor line that survives a reset. Reset cannot clear such a line, so its power-up value is unknown. The stimulus first acknowledges every hart to bring the lines to a known state, then raises some lines, asserts reset in the middle of the run, and confirms that only the machine-personality copy loses its flags. Two other corners also need careful stimulus: set and acknowledge landing on the same edge, and a read that coincides with a write to the same hart. A set/clear pattern plus an acknowledge reaches each of them on a chosen cycle.

// File: rtl/swi_pkg.sv
package swi_pkg;
  typedef enum logic {
    SWI_MACHINE    = 1'b0,
    SWI_SUPERVISOR = 1'b1
  } swi_mode_e;

  localparam int unsigned BUS_W = 32;
endpackage

// File: rtl/swi_addr_dec.sv
module swi_addr_dec #(
  parameter int unsigned HARTS  = 4,
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  output logic [HARTS-1:0]  sel
);
  logic        aligned;
  logic [31:0] word_idx;

  assign aligned  = (addr[1:0] == 2'b00);
  assign word_idx = 32'(addr[ADDR_W-1:2]);

  for (genvar g = 0; g < HARTS; g++) begin : g_sel
    assign sel[g] = aligned && (word_idx == 32'(g));
  end

  a_r8_misaligned_no_sel : assert property (@(posedge clk) disable iff (rst)
    (addr[1:0] != 2'b00) |-> (sel == '0));
  a_r9_range_no_sel : assert property (@(posedge clk) disable iff (rst)
    (word_idx >= 32'(HARTS)) |-> (sel == '0));
  a_r1_single_sel : assert property (@(posedge clk) disable iff (rst)
    $onehot0(sel));
endmodule

// File: rtl/swi_cell.sv
module swi_cell #(
  parameter swi_pkg::swi_mode_e MODE = swi_pkg::SWI_MACHINE
) (
  input  logic clk,
  input  logic rst,
  input  logic wr_hit,
  input  logic wbit,
  input  logic ack,
  output logic pend
);
  if (MODE == swi_pkg::SWI_MACHINE) begin : g_mach
    logic unused_ack;
    assign unused_ack = ack;

    always_ff @(posedge clk) begin
      if (rst)         pend <= 1'b0;
      else if (wr_hit) pend <= wbit;
    end

    a_r2_write_takes : assert property (@(posedge clk) disable iff (rst)
      wr_hit |=> (pend == $past(wbit)));
    a_r7_hold_without_write : assert property (@(posedge clk) disable iff (rst)
      !wr_hit |=> $stable(pend));
    a_r10_clear_after_reset : assert property (@(posedge clk)
      $fell(rst) |-> !pend);
  end else begin : g_sup
    logic unused_rst;
    assign unused_rst = rst;

    always_ff @(posedge clk) begin
      if (wr_hit && wbit) pend <= 1'b1;
      else if (ack)       pend <= 1'b0;
    end

    a_r6_set_beats_ack : assert property (@(posedge clk) disable iff (rst)
      (wr_hit && wbit) |=> pend);
    a_r6_ack_clears : assert property (@(posedge clk) disable iff (rst)
      (ack && !(wr_hit && wbit)) |=> !pend);
    a_r5_zero_write_holds : assert property (@(posedge clk) disable iff (rst)
      (!(wr_hit && wbit) && !ack) |=> $stable(pend));
  end
endmodule

// File: rtl/swi_rd_path.sv
module swi_rd_path #(
  parameter int unsigned        HARTS = 4,
  parameter swi_pkg::swi_mode_e MODE  = swi_pkg::SWI_MACHINE
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      rd,
  input  logic [HARTS-1:0]          sel,
  input  logic [HARTS-1:0]          pend,
  output logic [swi_pkg::BUS_W-1:0] rdata
);
  logic rd_bit;

  if (MODE == swi_pkg::SWI_MACHINE) begin : g_mach
    assign rd_bit = rd && |(sel & pend);
  end else begin : g_sup
    logic unused_rd;
    assign unused_rd = rd ^ (|sel) ^ (|pend);
    assign rd_bit    = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= {{(swi_pkg::BUS_W-1){1'b0}}, rd_bit};
  end

  a_r3_upper_zero : assert property (@(posedge clk) disable iff (rst)
    rdata[swi_pkg::BUS_W-1:1] == '0);
  a_r3_idle_zero : assert property (@(posedge clk) disable iff (rst)
    !rd |=> (rdata == '0));
  if (MODE == swi_pkg::SWI_SUPERVISOR) begin : g_chk_sup
    a_r4_reads_zero : assert property (@(posedge clk) disable iff (rst)
      rd |=> (rdata == '0));
  end
endmodule

// File: rtl/swi_bank.sv
module swi_bank #(
  parameter int unsigned        HARTS  = 4,
  parameter int unsigned        ADDR_W = 12,
  parameter swi_pkg::swi_mode_e MODE   = swi_pkg::SWI_MACHINE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [31:0]       bus_rdata,
  input  logic [HARTS-1:0]  hart_ack,
  output logic [HARTS-1:0]  sw_irq
);
  logic [HARTS-1:0] sel;
  logic [HARTS-1:0] pend;
  logic             unused_wdata;

  assign unused_wdata = ^bus_wdata[31:1];

  swi_addr_dec #(.HARTS(HARTS), .ADDR_W(ADDR_W)) u_dec (
    .clk (clk),
    .rst (rst),
    .addr(bus_addr),
    .sel (sel)
  );

  for (genvar g = 0; g < HARTS; g++) begin : g_hart
    swi_cell #(.MODE(MODE)) u_cell (
      .clk   (clk),
      .rst   (rst),
      .wr_hit(bus_wr && sel[g]),
      .wbit  (bus_wdata[0]),
      .ack   (hart_ack[g]),
      .pend  (pend[g])
    );
  end

  swi_rd_path #(.HARTS(HARTS), .MODE(MODE)) u_rd (
    .clk  (clk),
    .rst  (rst),
    .rd   (bus_rd),
    .sel  (sel),
    .pend (pend),
    .rdata(bus_rdata)
  );

  assign sw_irq = pend;

  a_r1_set_raises : assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_wdata[0] && (sel != '0)) |=> ((sw_irq & $past(sel)) != '0));
  a_r9_unselected_write_no_rise : assert property (@(posedge clk) disable iff (rst)
    (bus_wr && (sel == '0) && (hart_ack == '0)) |=> $stable(sw_irq));
endmodule

// File: tb/swi_bank_bench.sv
module swi_bank_bench;
  localparam int HARTS  = 4;
  localparam int ADDR_W = 12;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic              bus_wr = 1'b0;
  logic              bus_rd = 1'b0;
  logic [HARTS-1:0]  hart_ack = '0;
  logic [31:0]       rdata_m, rdata_s;
  logic [HARTS-1:0]  irq_m, irq_s;

  always #2 clk = ~clk;

  swi_bank #(.HARTS(HARTS), .ADDR_W(ADDR_W), .MODE(swi_pkg::SWI_MACHINE)) u_swi_bank (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(rdata_m),
    .hart_ack(hart_ack), .sw_irq(irq_m));

  swi_bank #(.HARTS(HARTS), .ADDR_W(ADDR_W), .MODE(swi_pkg::SWI_SUPERVISOR)) u_swi_bank_sup (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(rdata_s),
    .hart_ack(hart_ack), .sw_irq(irq_s));

  int    checks = 0;
  int    failures = 0;
  string cur_req = "R10";
  bit    s_known = 1'b0;
  bit    done = 1'b0;

  bit [HARTS-1:0] exp_m = '0;
  bit [HARTS-1:0] exp_s = '0;
  bit [31:0]      exp_rdm = '0;
  bit [31:0]      exp_rds = '0;

  // Behavioural reference, updated on every rising edge
  always @(posedge clk) begin
    int idx;
    bit hit;
    idx = int'(bus_addr) / 4;
    hit = (bus_addr[1:0] == 2'b00) && (idx < HARTS);
    if (rst) begin
      exp_m   <= '0;
      exp_rdm <= '0;
    end else begin
      exp_rdm <= (bus_rd && hit) ? {31'b0, exp_m[idx]} : 32'b0;
      if (bus_wr && hit) exp_m[idx] <= bus_wdata[0];
    end
    exp_rds <= '0;
    for (int i = 0; i < HARTS; i++) begin
      if (bus_wr && hit && idx == i && bus_wdata[0]) exp_s[i] <= 1'b1;
      else if (hart_ack[i])                         exp_s[i] <= 1'b0;
    end
  end

  task automatic check32(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
    end
  endtask

  // Compare on every falling edge
  always @(negedge clk) begin
    if (!done) begin
      check32("irq_machine", 32'(irq_m), 32'(exp_m));
      check32("rdata_machine", rdata_m, exp_rdm);
      check32("rdata_supervisor", rdata_s, exp_rds);
      if (s_known) check32("irq_supervisor", 32'(irq_s), 32'(exp_s));
    end
  end

  task automatic cyc(logic wr, logic rd, int addr, logic [31:0] wd, logic [HARTS-1:0] ack);
    @(posedge clk);
    #1;
    bus_wr = wr; bus_rd = rd; bus_addr = ADDR_W'(addr);
    bus_wdata = wd; hart_ack = ack;
  endtask

  task automatic idle();
    cyc(1'b0, 1'b0, 0, 32'h0, '0);
  endtask

  initial begin
    // R10: reset state
    cur_req = "R10";
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // bring supervisor lines to a known state
    cyc(1'b0, 1'b0, 0, 0, '1);
    idle();
    @(negedge clk); s_known = 1'b1;

    // R1: set each hart at offset 4*i
    cur_req = "R1";
    for (int i = 0; i < HARTS; i++) cyc(1'b1, 1'b0, 4*i, 32'h1, '0);
    idle();
    // R3 / R4: read back each hart
    cur_req = "R3_R4";
    for (int i = 0; i < HARTS; i++) cyc(1'b0, 1'b1, 4*i, 0, '0);
    idle();

    // R2 / R5: zero bit 0 with upper bits set
    cur_req = "R2_R5";
    cyc(1'b1, 1'b0, 4, 32'hFFFF_FFFE, '0);
    cyc(1'b0, 1'b1, 4, 0, '0);
    cyc(1'b1, 1'b0, 4, 32'hFFFF_FFFF, '0);
    cyc(1'b0, 1'b1, 4, 0, '0);
    idle();

    // R7 / R6: ack hart 0 — machine ignores it, supervisor clears
    cur_req = "R7_R6";
    cyc(1'b0, 1'b0, 0, 0, 4'b0001);
    cyc(1'b0, 1'b1, 0, 0, '0);
    // R6: set and ack the same hart together
    cur_req = "R6";
    cyc(1'b0, 1'b0, 0, 0, 4'b0100);
    cyc(1'b1, 1'b0, 8, 32'h1, 4'b0100);
    idle();

    // R8: misaligned accesses
    cur_req = "R8";
    cyc(1'b1, 1'b0, 1, 32'h1, '0);
    cyc(1'b1, 1'b0, 6, 32'h0, '0);
    cyc(1'b0, 1'b1, 5, 0, '0);
    cyc(1'b0, 1'b1, 2, 0, '0);
    idle();

    // R9: out-of-range accesses
    cur_req = "R9";
    cyc(1'b1, 1'b0, 4*HARTS, 32'h0, '0);
    cyc(1'b1, 1'b0, 4*HARTS + 4, 32'h1, '0);
    cyc(1'b0, 1'b1, 4*HARTS, 0, '0);
    cyc(1'b0, 1'b1, 12'hFFC, 0, '0);
    idle();

    // R12: read and write the same hart together
    cur_req = "R12";
    cyc(1'b1, 1'b1, 12, 32'h0, '0);
    cyc(1'b0, 1'b1, 12, 0, '0);
    cyc(1'b1, 1'b1, 12, 32'h1, '0);
    cyc(1'b0, 1'b1, 12, 0, '0);
    idle();

    // R11 / R10: reset mid-run with lines raised
    cur_req = "R11_R10";
    cyc(1'b1, 1'b0, 0, 32'h1, '0);
    idle();
    @(posedge clk); #1 rst = 1'b1;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
    cyc(1'b0, 1'b1, 0, 0, '0);
    idle();
    idle();
    @(negedge clk);
    // R11: explicit port check that supervisor lines survived
    checks++;
    if (irq_s !== 4'b1111) begin
      failures++;
      $display("FAIL R11 irq_supervisor actual=%b expected=%b", irq_s, 4'b1111);
    end
    // R10: explicit port check that machine lines were cleared
    checks++;
    if (irq_m !== 4'b0000) begin
      failures++;
      $display("FAIL R10 irq_machine actual=%b expected=%b", irq_m, 4'b0000);
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #20000;
    failures++;
    checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule